// File: doc/BRIEF.md
# PC-Indexed Correlation Prefetch Table

This block holds a small set of learned load correlations, each a pair of a load PC and a signed byte offset. A separate extractor, outside this block, confirms that the load at some PC is regularly followed by a load whose address is a fixed distance away. When it does, it pushes the pair in through the insert port. The table is direct-mapped and indexed by PC bits. On every memory access the core presents the access PC and source address on the probe port. If the PC matches a stored entry, the block adds the stored offset to the source address and rounds the sum down to a block boundary. It then emits a prefetch request for that block, aimed at the small buffer that sits in front of the first-level data cache.

The block is not on the load's critical path, so its single pipeline register is acceptable. A probe accepted at clock edge N shows up as a one-cycle `pf_valid` pulse in the cycle after edge N. Both the insert and probe inputs are valid-only, with no ready. The block accepts one insert and one probe on every clock and never stalls either producer. Prefetches are hints, so the prefetch output offers no back-pressure, and the consumer must take or discard each pulse in the cycle it appears.

Top module: `corr_prefetch_table`

## Requirements
- R1: After reset every entry is invalid and `pf_valid` is 0, so every probe misses until an insert lands.
- R2: A probe with `acc_valid`=1 that hits produces `pf_valid`=1 in the next cycle. In that cycle `pf_addr` is the source address plus the stored offset, aligned down.
- R3: The stored offset is an 8-bit two's-complement value, sign-extended before the add. The 32-bit sum wraps modulo 2^32.
- R4: The prefetch address is aligned down to a 16-byte block, so bits 3:0 of `pf_addr` are 0.
- R5: A probe whose indexed entry is invalid, or whose tag differs, produces no prefetch.
- R6: When an insert and a probe use the same index in the same cycle, the probe sees the entry as it was before the insert. The insert takes effect at that clock edge.
- R7: `pf_valid` is high only in the cycle after a cycle with `acc_valid`=1. Each probe yields at most a one-cycle pulse, and back-to-back hits give back-to-back pulses.
- R8: An insert overwrites the entry at its index unconditionally. An older PC that shared the index then misses.
- R9: The index is PC bits 5:2 and the tag is PC bits 31:6. PC bits 1:0 take no part in the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | 1 | Insert request from the extractor |
| ins_pc | input | 32 | PC of the correlated load to store |
| ins_offset | input | 8 | Signed byte offset to store |
| acc_valid | input | 1 | A memory access is being probed this cycle |
| acc_pc | input | 32 | PC of the access |
| acc_addr | input | 32 | Source address of the access |
| pf_valid | output | 1 | One-cycle prefetch request pulse |
| pf_addr | output | 32 | Block-aligned prefetch address |

## Verification
The probe is tried against several kinds of table entry:
- an empty entry after reset;
- an entry with a matching tag, using positive, negative and extreme offsets;
- an entry that holds a different tag at the same index;
- an entry that was just overwritten.

Together these separate a true tag compare from an index-only lookup and a correct sign extension from a zero extension. Source addresses with nonzero low bits, and a sum that wraps below zero, show whether the alignment and modular add are right. Probes issued in the same cycle as an insert to their own index tell old-content reads apart from write-through. Idle cycles and back-to-back hits expose pulses that are stretched or missing.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  localparam int unsigned CPT_PC_W      = 32;
  localparam int unsigned CPT_ADDR_W    = 32;
  localparam int unsigned CPT_OFF_W     = 8;
  localparam int unsigned CPT_ENTRIES   = 16;
  localparam int unsigned CPT_BLK_BYTES = 16;
  localparam int unsigned CPT_PC_LSB    = 2;
endpackage

// File: rtl/cpt_table.sv
module cpt_table #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned TAG_W   = 26,
  parameter int unsigned OFF_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic [TAG_W-1:0] rd_tag,
  output logic [OFF_W-1:0] rd_off
);
  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [OFF_W-1:0]   off_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    localparam logic [IDX_W-1:0] GI = IDX_W'(g);
    logic hit_wr;
    assign hit_wr = wr_en && (wr_idx == GI);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q[g] <= 1'b0;
      else if (hit_wr) vld_q[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit_wr) begin
        tag_q[g] <= wr_tag;
        off_q[g] <= wr_off;
      end
    end
  end

  // Reads see the contents before any write at the same edge.
  assign rd_vld = vld_q[rd_idx];
  assign rd_tag = tag_q[rd_idx];
  assign rd_off = off_q[rd_idx];

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (vld_q == '0));
  a_r8_insert_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)]);
  a_r8_valid_only_by_insert: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(vld_q));
endmodule

// File: rtl/cpt_match.sv
module cpt_match #(
  parameter int unsigned TAG_W = 26
) (
  input  logic             ent_vld,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [TAG_W-1:0] probe_tag,
  output logic             hit
);
  assign hit = ent_vld && (ent_tag == probe_tag);
endmodule

// File: rtl/cpt_addr_gen.sv
module cpt_addr_gen #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned OFF_W     = 8,
  parameter int unsigned BLK_BYTES = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] target
);
  localparam int unsigned BLK_W = $clog2(BLK_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << BLK_W) - ADDR_W'(1));

  logic [ADDR_W-1:0] off_sx;
  logic [ADDR_W-1:0] sum;

  assign off_sx = {{(ADDR_W-OFF_W){off[OFF_W-1]}}, off};
  assign sum    = base + off_sx;
  assign target = sum & ALIGN_MASK;
endmodule

// File: rtl/corr_prefetch_table.sv
module corr_prefetch_table
  import cpt_pkg::*;
#(
  parameter int unsigned PC_W      = CPT_PC_W,
  parameter int unsigned ADDR_W    = CPT_ADDR_W,
  parameter int unsigned OFF_W     = CPT_OFF_W,
  parameter int unsigned ENTRIES   = CPT_ENTRIES,
  parameter int unsigned BLK_BYTES = CPT_BLK_BYTES,
  parameter int unsigned PC_LSB    = CPT_PC_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [PC_W-1:0]   ins_pc,
  input  logic [OFF_W-1:0]  ins_offset,
  input  logic              acc_valid,
  input  logic [PC_W-1:0]   acc_pc,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned TAG_W = PC_W - PC_LSB - IDX_W;
  localparam int unsigned BLK_W = $clog2(BLK_BYTES);

  logic [IDX_W-1:0]  ins_idx, acc_idx;
  logic [TAG_W-1:0]  ins_tag, acc_tag;
  logic              ent_vld;
  logic [TAG_W-1:0]  ent_tag;
  logic [OFF_W-1:0]  ent_off;
  logic              lk_hit;
  logic [ADDR_W-1:0] tgt;

  assign ins_idx = ins_pc[PC_LSB +: IDX_W];
  assign acc_idx = acc_pc[PC_LSB +: IDX_W];
  assign ins_tag = ins_pc[PC_W-1 -: TAG_W];
  assign acc_tag = acc_pc[PC_W-1 -: TAG_W];

  if (PC_LSB > 0) begin : g_lsb
    logic unused_pc_lsb;
    assign unused_pc_lsb = ^{ins_pc[PC_LSB-1:0], acc_pc[PC_LSB-1:0]};
  end

  cpt_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ins_valid),
    .wr_idx (ins_idx),
    .wr_tag (ins_tag),
    .wr_off (ins_offset),
    .rd_idx (acc_idx),
    .rd_vld (ent_vld),
    .rd_tag (ent_tag),
    .rd_off (ent_off)
  );

  cpt_match #(.TAG_W(TAG_W)) u_match (
    .ent_vld   (ent_vld),
    .ent_tag   (ent_tag),
    .probe_tag (acc_tag),
    .hit       (lk_hit)
  );

  cpt_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BLK_BYTES(BLK_BYTES)) u_addr (
    .base   (acc_addr),
    .off    (ent_off),
    .target (tgt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else begin
      pf_valid <= acc_valid && lk_hit;
      if (acc_valid && lk_hit) pf_addr <= tgt;
    end
  end

  a_r7_pulse_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> $past(acc_valid));
  a_r5_pulse_needs_valid_entry: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> $past(ent_vld));
  a_r4_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (pf_addr[BLK_W-1:0] == '0));
endmodule

// File: tb/tb_corr_prefetch_table.sv
module tb_corr_prefetch_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic [31:0] ins_pc = '0;
  logic [7:0]  ins_offset = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_pc = '0;
  logic [31:0] acc_addr = '0;
  logic        pf_valid;
  logic [31:0] pf_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  corr_prefetch_table dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_pc(ins_pc),
    .ins_offset(ins_offset), .acc_valid(acc_valid), .acc_pc(acc_pc),
    .acc_addr(acc_addr), .pf_valid(pf_valid), .pf_addr(pf_addr)
  );

  typedef struct packed {
    logic        iv;
    logic [31:0] ipc;
    logic [7:0]  ioff;
    logic        av;
    logic [31:0] apc;
    logic [31:0] aad;
    logic        ev;
    logic [31:0] ead;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h0,   8'h00, 1'b1, 32'h100, 32'h1000, 1'b0, 32'h0,        8'd1}, // R1 empty
    '{1'b1, 32'h100, 8'h20, 1'b1, 32'h100, 32'h2000, 1'b0, 32'h0,        8'd6}, // R6 same cycle
    '{1'b0, 32'h0,   8'h00, 1'b1, 32'h100, 32'h2000, 1'b1, 32'h2020,     8'd2}, // R2 hit
    '{1'b0, 32'h0,   8'h00, 1'b1, 32'h100, 32'h2008, 1'b1, 32'h2020,     8'd4}, // R4 align
    '{1'b1, 32'h104, 8'hF0, 1'b1, 32'h104, 32'h3000, 1'b0, 32'h0,        8'd6}, // R6
    '{1'b0, 32'h0,   8'h00, 1'b1, 32'h104, 32'h3005, 1'b1, 32'h2FF0,     8'd3}, // R3 negative
    '{1'b0, 32'h0,   8'h00, 1'b1, 32'h140, 32'h2000, 1'b0, 32'h0,        8'd5}, // R5 tag differs
    '{1'b0, 32'h0,   8'h00, 1'b0, 32'h100, 32'h2000, 1'b0, 32'h0,        8'd7}, // R7 no access
    '{1'b1, 32'h140, 8'h7F, 1'b0, 32'h0,   32'h0,    1'b0, 32'h0,        8'd7}, // R7 idle insert
    '{1'b0, 32'h0,   8'h00, 1'b1, 32'h100, 32'h2000, 1'b0, 32'h0,        8'd8}, // R8 evicted
    '{1'b0, 32'h0,   8'h00, 1'b1, 32'h140, 32'h1000, 1'b1, 32'h1070,     8'd8}, // R8 new owner
    '{1'b0, 32'h0,   8'h00, 1'b1, 32'h143, 32'h0500, 1'b1, 32'h0570,     8'd9}, // R9 low bits
    '{1'b1, 32'h13C, 8'h80, 1'b1, 32'h13C, 32'h0040, 1'b0, 32'h0,        8'd6}, // R6
    '{1'b0, 32'h0,   8'h00, 1'b1, 32'h13C, 32'h0040, 1'b1, 32'hFFFFFFC0, 8'd3}, // R3 wrap
    '{1'b0, 32'h0,   8'h00, 1'b1, 32'h140, 32'h2000, 1'b1, 32'h2070,     8'd7}, // R7 back-to-back
    '{1'b0, 32'h0,   8'h00, 1'b0, 32'h0,   32'h0,    1'b0, 32'h0,        8'd7}  // R7 pulse ends
  };

  task automatic check(input logic ev, input logic [31:0] ead, input int rq, input string what);
    n_chk++;
    if (pf_valid !== ev || (ev && pf_addr !== ead)) begin
      n_fail++;
      $display("FAIL R%0d %s: got valid=%0b addr=%h, expected valid=%0b addr=%h",
               rq, what, pf_valid, pf_addr, ev, ead);
    end
  endtask

  task automatic drive(input logic iv, input logic [31:0] ipc, input logic [7:0] ioff,
                       input logic av, input logic [31:0] apc, input logic [31:0] aad);
    ins_valid = iv; ins_pc = ipc; ins_offset = ioff;
    acc_valid = av; acc_pc = apc; acc_addr = aad;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, 32'h0, 1, "pf_valid low in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, 32'h0, 1, "pf_valid low after reset");
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].iv, VEC[i].ipc, VEC[i].ioff, VEC[i].av, VEC[i].apc, VEC[i].aad);
      @(posedge clk);
      @(negedge clk);
      check(VEC[i].ev, VEC[i].ead, int'(VEC[i].req), $sformatf("vector %0d", i));
    end
    // R1: reset in mid-run discards learned entries
    drive(1'b0, 32'h0, 8'h0, 1'b0, 32'h0, 32'h0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    drive(1'b0, 32'h0, 8'h0, 1'b1, 32'h140, 32'h2000);
    @(posedge clk);
    @(negedge clk);
    check(1'b0, 32'h0, 1, "entry cleared by reset");
    // R2: re-learn and hit with largest positive offset
    drive(1'b1, 32'h200, 8'h7F, 1'b0, 32'h0, 32'h0);
    @(negedge clk);
    drive(1'b0, 32'h0, 8'h0, 1'b1, 32'h200, 32'h0000_1001);
    @(posedge clk);
    @(negedge clk);
    check(1'b1, 32'h0000_1080, 2, "max positive offset");
    drive(1'b0, 32'h0, 8'h0, 1'b0, 32'h0, 32'h0);
    @(negedge clk);
    check(1'b0, 32'h0, 7, "single pulse");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog expired: got running, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule